// File: doc/BRIEF.md
# Logical-Page Memory Address Translator

This block sits between a set of memory ports and a pool of equal-sized on-chip RAM elements. Each memory port is bound to one logical page. A page is built from an ordered list of RAM elements, and that list can grow or shrink at run time. Every access that a port presents is translated in the same cycle into a physical element number and a word offset inside that element. The access is forwarded only if it lies inside the page's current depth and its direction is permitted. A rejected access raises a per-port illegal flag in the next cycle.

A single controller changes the tables through a request channel and receives one response for every request. The request channel is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. After that, `req_ready` stays low and `busy` stays high until the response is consumed. The response channel is also valid/ready. `rsp_valid` and every response field hold steady while `rsp_ready` is low, and the response is consumed on the edge where both are high. Grow takes the lowest-numbered free element. Shrink returns the element that was added to the page most recently.

Top module: `bpt_translator`

## Requirements
- R1: After reset, `req_ready` is high and `rsp_valid`, `busy` and every `illegal` bit are low. Every port holds no access rights and every page is empty, so any access is rejected.
- R2: An accepted access drives `bram_en` in the same cycle as `acc_valid`. `bram_elem` is entry `acc_addr >> log2(ELEM_DEPTH)` of the page's element list, and `bram_off` is the low log2(ELEM_DEPTH) address bits.
- R3: An access whose element index is not below the page's current depth is rejected. `bram_en` stays low and `illegal` for that port is high in the following cycle. An access that is not rejected leaves that `illegal` bit low in the following cycle.
- R4: Rights are coded as bit 0 = read allowed and bit 1 = write allowed. The effective rights are the AND of the port's rights and the page's rights. A read without bit 0, or a write without bit 1, is rejected in the same way as in R3.
- R5: Grow (op 2) on a page below its maximum takes the lowest-numbered free element and appends it to the page. The response is code 0 (ACK), with the new depth and the granted element in `rsp_elem`.
- R6: Grow is answered with code 1 (NACK-full) and leaves the tables unchanged when the page is at its maximum depth or no element is free.
- R7: Shrink (op 3) removes the element added most recently and returns it to the free pool. The response is ACK with the new depth and the released element in `rsp_elem`. Shrink of a page with zero elements is answered with code 2 (NACK-empty).
- R8: Any request that names a page number of `NUM_PAGES` or above is answered with code 3 (NACK-bad-page) and changes nothing.
- R9: Only one request is outstanding at a time. `req_ready` is low and `busy` is high from acceptance until the response is consumed, and the response holds stable while `rsp_ready` is low.
- R10: The tables change on the clock edge that ends the cycle after acceptance. An access presented during that cycle is translated with the tables as they were before the change.
- R11: Set-page (op 1) writes the page's rights, word width (shown on `bram_width` for ports bound to it) and maximum depth, with values above `MAX_ELEMS` capped. A request whose capped maximum is below the current depth is answered with NACK-full and changes nothing.
- R12: Bind (op 0) sets the port's page and rights and answers ACK with that page's current depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | NUM_PORTS | Access request per port |
| acc_we | input | NUM_PORTS | Access is a write (1) or read (0) |
| acc_addr | input | NUM_PORTS x AW | Logical word address per port |
| bram_en | output | NUM_PORTS | Translated access forwarded |
| bram_we | output | NUM_PORTS | Direction of forwarded access |
| bram_elem | output | NUM_PORTS x EW | Physical element number |
| bram_off | output | NUM_PORTS x OFFW | Word offset inside the element |
| bram_width | output | NUM_PORTS x WIDTH_FW | Word width of the bound page |
| illegal | output | NUM_PORTS | Rejected access in previous cycle |
| req_valid | input | 1 | Control request valid |
| req_ready | output | 1 | Control request can be taken |
| req_op | input | 2 | 0 bind, 1 set-page, 2 grow, 3 shrink |
| req_port | input | PW | Port for bind |
| req_page | input | PGW | Target page |
| req_rights | input | 2 | Rights for bind or set-page |
| req_max | input | DW | Maximum depth for set-page |
| req_width | input | WIDTH_FW | Word width for set-page |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_code | output | 2 | 0 ACK, 1 NACK-full, 2 NACK-empty, 3 NACK-bad-page |
| rsp_depth | output | DW | Page depth after the request |
| rsp_elem | output | EW | Element granted or released |
| busy | output | 1 | Request in progress |

## Verification
An access translation and a table update can fall in the same cycle. This happens when a port reads the topmost element of its page during the cycle in which a shrink of that page is being executed. The bench accepts a shrink request, and in the very next cycle it drives a read of the element about to be removed. It expects that read to be forwarded to the old element with no illegal flag. After the response has been consumed, the bench repeats the same read and expects it to be rejected.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  typedef enum logic [1:0] {
    OP_BIND    = 2'd0,
    OP_SETPAGE = 2'd1,
    OP_GROW    = 2'd2,
    OP_SHRINK  = 2'd3
  } bpt_op_e;

  typedef enum logic [1:0] {
    RSP_ACK        = 2'd0,
    RSP_NACK_FULL  = 2'd1,
    RSP_NACK_EMPTY = 2'd2,
    RSP_NACK_BADPG = 2'd3
  } bpt_rsp_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_EXEC = 2'd1,
    S_RESP = 2'd2
  } bpt_state_e;

  localparam int RIGHT_RD = 0;
  localparam int RIGHT_WR = 1;
endpackage

// File: rtl/bpt_free_pool.sv
module bpt_free_pool #(
  parameter int NUM_ELEMS = 8,
  parameter int EW        = $clog2(NUM_ELEMS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic          give_i,
  input  logic [EW-1:0] give_idx_i,
  output logic          any_free_o,
  output logic [EW-1:0] low_idx_o
);
  logic [NUM_ELEMS-1:0] free_q;

  // lowest-numbered free element wins
  always_comb begin
    any_free_o = |free_q;
    low_idx_o  = '0;
    for (int k = NUM_ELEMS - 1; k >= 0; k--) begin
      if (free_q[k]) low_idx_o = EW'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q <= '1;
    end else begin
      if (take_i) free_q[low_idx_o]  <= 1'b0;
      if (give_i) free_q[give_idx_i] <= 1'b1;
    end
  end
endmodule

// File: rtl/bpt_page_store.sv
module bpt_page_store #(
  parameter int NUM_PAGES = 3,
  parameter int MAX_ELEMS = 4,
  parameter int EW        = 3,
  parameter int HIW       = 2,
  parameter int DW        = 3,
  parameter int WIDTH_FW  = 6,
  parameter int PGW       = 2,
  parameter int DEF_WIDTH = 32
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [PGW-1:0]                            sel_i,
  input  logic                                      cfg_en_i,
  input  logic [1:0]                                cfg_rights_i,
  input  logic [DW-1:0]                             cfg_max_i,
  input  logic [WIDTH_FW-1:0]                       cfg_width_i,
  input  logic                                      push_en_i,
  input  logic [EW-1:0]                             push_elem_i,
  input  logic                                      pop_en_i,
  output logic [NUM_PAGES-1:0][1:0]                 rights_o,
  output logic [NUM_PAGES-1:0][WIDTH_FW-1:0]        width_o,
  output logic [NUM_PAGES-1:0][DW-1:0]              max_o,
  output logic [NUM_PAGES-1:0][DW-1:0]              depth_o,
  output logic [NUM_PAGES-1:0][MAX_ELEMS-1:0][EW-1:0] list_o
);
  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    logic hit;
    assign hit = (sel_i == PGW'(p));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rights_o[p] <= 2'b11;
        width_o[p]  <= WIDTH_FW'(DEF_WIDTH);
        max_o[p]    <= DW'(MAX_ELEMS);
        depth_o[p]  <= '0;
        list_o[p]   <= '0;
      end else if (hit) begin
        if (cfg_en_i) begin
          rights_o[p] <= cfg_rights_i;
          width_o[p]  <= cfg_width_i;
          max_o[p]    <= cfg_max_i;
        end
        if (push_en_i) begin
          list_o[p][depth_o[p][HIW-1:0]] <= push_elem_i;
          depth_o[p] <= depth_o[p] + DW'(1);
        end
        if (pop_en_i) begin
          depth_o[p] <= depth_o[p] - DW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bpt_port_xlate.sv
module bpt_port_xlate #(
  parameter int NUM_PAGES = 3,
  parameter int MAX_ELEMS = 4,
  parameter int EW        = 3,
  parameter int HIW       = 2,
  parameter int DW        = 3,
  parameter int WIDTH_FW  = 6,
  parameter int PGW       = 2,
  parameter int OFFW      = 4,
  parameter int AW        = 6
) (
  input  logic                                        acc_valid_i,
  input  logic                                        acc_we_i,
  input  logic [AW-1:0]                               acc_addr_i,
  input  logic [PGW-1:0]                              page_i,
  input  logic [1:0]                                  port_rights_i,
  input  logic [NUM_PAGES-1:0][1:0]                   pg_rights_i,
  input  logic [NUM_PAGES-1:0][WIDTH_FW-1:0]          pg_width_i,
  input  logic [NUM_PAGES-1:0][DW-1:0]                pg_depth_i,
  input  logic [NUM_PAGES-1:0][MAX_ELEMS-1:0][EW-1:0] pg_list_i,
  output logic                                        en_o,
  output logic                                        we_o,
  output logic [EW-1:0]                               elem_o,
  output logic [OFFW-1:0]                             off_o,
  output logic [WIDTH_FW-1:0]                         width_o,
  output logic                                        reject_o
);
  import bpt_pkg::*;

  logic [1:0]                    eff_rights;
  logic [DW-1:0]                 depth;
  logic [MAX_ELEMS-1:0][EW-1:0]  row;
  logic [HIW-1:0]                hi;
  logic                          in_range;
  logic                          dir_ok;

  always_comb begin
    eff_rights = '0;
    depth      = '0;
    row        = '0;
    width_o    = '0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      if (page_i == PGW'(p)) begin
        eff_rights = port_rights_i & pg_rights_i[p];
        depth      = pg_depth_i[p];
        row        = pg_list_i[p];
        width_o    = pg_width_i[p];
      end
    end
    hi       = acc_addr_i[AW-1:OFFW];
    in_range = {1'b0, hi} < depth;
    dir_ok   = acc_we_i ? eff_rights[RIGHT_WR] : eff_rights[RIGHT_RD];
    en_o     = acc_valid_i && in_range && dir_ok;
    reject_o = acc_valid_i && !(in_range && dir_ok);
    we_o     = acc_we_i;
    elem_o   = row[hi];
    off_o    = acc_addr_i[OFFW-1:0];
  end
endmodule

// File: rtl/bpt_req_ctrl.sv
module bpt_req_ctrl #(
  parameter int NUM_PORTS = 4,
  parameter int NUM_PAGES = 3,
  parameter int MAX_ELEMS = 4,
  parameter int EW        = 3,
  parameter int HIW       = 2,
  parameter int DW        = 3,
  parameter int WIDTH_FW  = 6,
  parameter int PGW       = 2,
  parameter int PW        = 2
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        req_valid_i,
  output logic                                        req_ready_o,
  input  logic [1:0]                                  req_op_i,
  input  logic [PW-1:0]                               req_port_i,
  input  logic [PGW-1:0]                              req_page_i,
  input  logic [1:0]                                  req_rights_i,
  input  logic [DW-1:0]                               req_max_i,
  input  logic [WIDTH_FW-1:0]                         req_width_i,
  output logic                                        rsp_valid_o,
  input  logic                                        rsp_ready_i,
  output logic [1:0]                                  rsp_code_o,
  output logic [DW-1:0]                               rsp_depth_o,
  output logic [EW-1:0]                               rsp_elem_o,
  output logic                                        busy_o,
  input  logic [NUM_PAGES-1:0][DW-1:0]                pg_depth_i,
  input  logic [NUM_PAGES-1:0][DW-1:0]                pg_max_i,
  input  logic [NUM_PAGES-1:0][MAX_ELEMS-1:0][EW-1:0] pg_list_i,
  input  logic                                        any_free_i,
  input  logic [EW-1:0]                               low_idx_i,
  output logic [PGW-1:0]                              sel_o,
  output logic                                        cfg_en_o,
  output logic [1:0]                                  cfg_rights_o,
  output logic [DW-1:0]                               cfg_max_o,
  output logic [WIDTH_FW-1:0]                         cfg_width_o,
  output logic                                        push_en_o,
  output logic [EW-1:0]                               push_elem_o,
  output logic                                        pop_en_o,
  output logic                                        take_o,
  output logic                                        give_o,
  output logic [EW-1:0]                               give_idx_o,
  output logic [NUM_PORTS-1:0][PGW-1:0]               port_page_o,
  output logic [NUM_PORTS-1:0][1:0]                   port_rights_o
);
  import bpt_pkg::*;

  bpt_state_e            state_q;
  bpt_op_e               op_q;
  logic [PW-1:0]         port_q;
  logic [PGW-1:0]        page_q;
  logic [1:0]            rights_q;
  logic [DW-1:0]         max_q;
  logic [WIDTH_FW-1:0]   width_q;

  logic                          bad;
  logic [DW-1:0]                 cur_depth;
  logic [DW-1:0]                 cur_max;
  logic [DW-1:0]                 dm1;
  logic [DW-1:0]                 capped;
  logic [MAX_ELEMS-1:0][EW-1:0]  cur_row;
  bpt_rsp_e                      code_n;
  logic [DW-1:0]                 depth_n;
  logic [EW-1:0]                 elem_n;
  logic                          bind_n;

  always_comb begin
    cur_depth = '0;
    cur_max   = '0;
    cur_row   = '0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      if (page_q == PGW'(p)) begin
        cur_depth = pg_depth_i[p];
        cur_max   = pg_max_i[p];
        cur_row   = pg_list_i[p];
      end
    end
    bad    = page_q >= PGW'(NUM_PAGES);
    capped = (max_q > DW'(MAX_ELEMS)) ? DW'(MAX_ELEMS) : max_q;
    dm1    = cur_depth - DW'(1);

    code_n    = RSP_ACK;
    depth_n   = cur_depth;
    elem_n    = '0;
    bind_n    = 1'b0;
    cfg_en_o  = 1'b0;
    push_en_o = 1'b0;
    pop_en_o  = 1'b0;
    take_o    = 1'b0;
    give_o    = 1'b0;

    if (state_q == S_EXEC) begin
      if (bad) begin
        code_n = RSP_NACK_BADPG;
      end else begin
        case (op_q)
          OP_BIND: bind_n = 1'b1;
          OP_SETPAGE: begin
            if (capped < cur_depth) code_n = RSP_NACK_FULL;
            else                    cfg_en_o = 1'b1;
          end
          OP_GROW: begin
            if (cur_depth >= cur_max || cur_depth >= DW'(MAX_ELEMS) || !any_free_i) begin
              code_n = RSP_NACK_FULL;
            end else begin
              push_en_o = 1'b1;
              take_o    = 1'b1;
              elem_n    = low_idx_i;
              depth_n   = cur_depth + DW'(1);
            end
          end
          OP_SHRINK: begin
            if (cur_depth == '0) begin
              code_n = RSP_NACK_EMPTY;
            end else begin
              pop_en_o = 1'b1;
              give_o   = 1'b1;
              elem_n   = cur_row[dm1[HIW-1:0]];
              depth_n  = dm1;
            end
          end
          default: code_n = RSP_NACK_BADPG;
        endcase
      end
    end
  end

  assign sel_o        = bad ? '0 : page_q;
  assign cfg_rights_o = rights_q;
  assign cfg_max_o    = capped;
  assign cfg_width_o  = width_q;
  assign push_elem_o  = low_idx_i;
  assign give_idx_o   = elem_n;
  assign req_ready_o  = (state_q == S_IDLE);
  assign rsp_valid_o  = (state_q == S_RESP);
  assign busy_o       = (state_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= S_IDLE;
      op_q          <= OP_BIND;
      port_q        <= '0;
      page_q        <= '0;
      rights_q      <= '0;
      max_q         <= '0;
      width_q       <= '0;
      rsp_code_o    <= '0;
      rsp_depth_o   <= '0;
      rsp_elem_o    <= '0;
      port_page_o   <= '0;
      port_rights_o <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (req_valid_i) begin
            op_q     <= bpt_op_e'(req_op_i);
            port_q   <= req_port_i;
            page_q   <= req_page_i;
            rights_q <= req_rights_i;
            max_q    <= req_max_i;
            width_q  <= req_width_i;
            state_q  <= S_EXEC;
          end
        end
        S_EXEC: begin
          rsp_code_o  <= code_n;
          rsp_depth_o <= depth_n;
          rsp_elem_o  <= elem_n;
          if (bind_n) begin
            port_page_o[port_q]   <= page_q;
            port_rights_o[port_q] <= rights_q;
          end
          state_q <= S_RESP;
        end
        default: begin
          if (rsp_ready_i) state_q <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/bpt_translator.sv
module bpt_translator #(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_PAGES  = 3,
  parameter int NUM_ELEMS  = 8,
  parameter int ELEM_DEPTH = 16,
  parameter int MAX_ELEMS  = 4,
  parameter int WIDTH_FW   = 6,
  parameter int DEF_WIDTH  = 32,
  localparam int OFFW = $clog2(ELEM_DEPTH),
  localparam int HIW  = $clog2(MAX_ELEMS),
  localparam int DW   = HIW + 1,
  localparam int AW   = OFFW + HIW,
  localparam int EW   = $clog2(NUM_ELEMS),
  localparam int PGW  = $clog2(NUM_PAGES + 1),
  localparam int PW   = $clog2(NUM_PORTS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_PORTS-1:0]               acc_valid,
  input  logic [NUM_PORTS-1:0]               acc_we,
  input  logic [NUM_PORTS-1:0][AW-1:0]       acc_addr,
  output logic [NUM_PORTS-1:0]               bram_en,
  output logic [NUM_PORTS-1:0]               bram_we,
  output logic [NUM_PORTS-1:0][EW-1:0]       bram_elem,
  output logic [NUM_PORTS-1:0][OFFW-1:0]     bram_off,
  output logic [NUM_PORTS-1:0][WIDTH_FW-1:0] bram_width,
  output logic [NUM_PORTS-1:0]               illegal,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic [1:0]                         req_op,
  input  logic [PW-1:0]                      req_port,
  input  logic [PGW-1:0]                     req_page,
  input  logic [1:0]                         req_rights,
  input  logic [DW-1:0]                      req_max,
  input  logic [WIDTH_FW-1:0]                req_width,
  output logic                               rsp_valid,
  input  logic                               rsp_ready,
  output logic [1:0]                         rsp_code,
  output logic [DW-1:0]                      rsp_depth,
  output logic [EW-1:0]                      rsp_elem,
  output logic                               busy
);
  logic [NUM_PAGES-1:0][1:0]                   pg_rights;
  logic [NUM_PAGES-1:0][WIDTH_FW-1:0]          pg_width;
  logic [NUM_PAGES-1:0][DW-1:0]                pg_max;
  logic [NUM_PAGES-1:0][DW-1:0]                pg_depth;
  logic [NUM_PAGES-1:0][MAX_ELEMS-1:0][EW-1:0] pg_list;
  logic [NUM_PORTS-1:0][PGW-1:0]               port_page;
  logic [NUM_PORTS-1:0][1:0]                   port_rights;
  logic [NUM_PORTS-1:0]                        reject;

  logic [PGW-1:0]      sel;
  logic                cfg_en, push_en, pop_en, take, give, any_free;
  logic [1:0]          cfg_rights;
  logic [DW-1:0]       cfg_max;
  logic [WIDTH_FW-1:0] cfg_width;
  logic [EW-1:0]       push_elem, give_idx, low_idx;

  bpt_req_ctrl #(
    .NUM_PORTS(NUM_PORTS), .NUM_PAGES(NUM_PAGES), .MAX_ELEMS(MAX_ELEMS),
    .EW(EW), .HIW(HIW), .DW(DW), .WIDTH_FW(WIDTH_FW), .PGW(PGW), .PW(PW)
  ) u_ctrl (
    .clk, .rst_n,
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_port_i(req_port), .req_page_i(req_page), .req_rights_i(req_rights),
    .req_max_i(req_max), .req_width_i(req_width),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_code_o(rsp_code),
    .rsp_depth_o(rsp_depth), .rsp_elem_o(rsp_elem), .busy_o(busy),
    .pg_depth_i(pg_depth), .pg_max_i(pg_max), .pg_list_i(pg_list),
    .any_free_i(any_free), .low_idx_i(low_idx),
    .sel_o(sel), .cfg_en_o(cfg_en), .cfg_rights_o(cfg_rights), .cfg_max_o(cfg_max),
    .cfg_width_o(cfg_width), .push_en_o(push_en), .push_elem_o(push_elem),
    .pop_en_o(pop_en), .take_o(take), .give_o(give), .give_idx_o(give_idx),
    .port_page_o(port_page), .port_rights_o(port_rights)
  );

  bpt_page_store #(
    .NUM_PAGES(NUM_PAGES), .MAX_ELEMS(MAX_ELEMS), .EW(EW), .HIW(HIW), .DW(DW),
    .WIDTH_FW(WIDTH_FW), .PGW(PGW), .DEF_WIDTH(DEF_WIDTH)
  ) u_store (
    .clk, .rst_n, .sel_i(sel), .cfg_en_i(cfg_en), .cfg_rights_i(cfg_rights),
    .cfg_max_i(cfg_max), .cfg_width_i(cfg_width), .push_en_i(push_en),
    .push_elem_i(push_elem), .pop_en_i(pop_en),
    .rights_o(pg_rights), .width_o(pg_width), .max_o(pg_max),
    .depth_o(pg_depth), .list_o(pg_list)
  );

  bpt_free_pool #(.NUM_ELEMS(NUM_ELEMS), .EW(EW)) u_pool (
    .clk, .rst_n, .take_i(take), .give_i(give), .give_idx_i(give_idx),
    .any_free_o(any_free), .low_idx_o(low_idx)
  );

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    bpt_port_xlate #(
      .NUM_PAGES(NUM_PAGES), .MAX_ELEMS(MAX_ELEMS), .EW(EW), .HIW(HIW), .DW(DW),
      .WIDTH_FW(WIDTH_FW), .PGW(PGW), .OFFW(OFFW), .AW(AW)
    ) u_xlate (
      .acc_valid_i(acc_valid[i]), .acc_we_i(acc_we[i]), .acc_addr_i(acc_addr[i]),
      .page_i(port_page[i]), .port_rights_i(port_rights[i]),
      .pg_rights_i(pg_rights), .pg_width_i(pg_width), .pg_depth_i(pg_depth),
      .pg_list_i(pg_list),
      .en_o(bram_en[i]), .we_o(bram_we[i]), .elem_o(bram_elem[i]),
      .off_o(bram_off[i]), .width_o(bram_width[i]), .reject_o(reject[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) illegal <= '0;
    else        illegal <= reject;
  end
endmodule

// File: rtl/bpt_checker.sv
module bpt_checker #(
  parameter int NUM_PORTS = 4,
  parameter int DW        = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PORTS-1:0] acc_valid,
  input logic [NUM_PORTS-1:0] bram_en,
  input logic [NUM_PORTS-1:0] illegal,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [1:0]           rsp_code,
  input logic [DW-1:0]        rsp_depth,
  input logic                 busy
);
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
    assert_reject_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid[i] && !bram_en[i] |=> illegal[i]);
    assert_accept_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid[i] && bram_en[i] |=> !illegal[i]);
    assert_idle_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid[i] |=> !illegal[i]);
    assert_en_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bram_en[i] |-> acc_valid[i]);
  end

  assert_one_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready);
  assert_rsp_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_depth));
  assert_rsp_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy);
endmodule

bind bpt_translator bpt_checker #(.NUM_PORTS(NUM_PORTS), .DW(DW)) u_chk (.*);

// File: tb/tb_bpt_translator.sv
module tb_bpt_translator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]       acc_valid = '0;
  logic [3:0]       acc_we = '0;
  logic [3:0][5:0]  acc_addr = '0;
  logic [3:0]       bram_en, bram_we, illegal;
  logic [3:0][2:0]  bram_elem;
  logic [3:0][3:0]  bram_off;
  logic [3:0][5:0]  bram_width;
  logic             req_valid = 1'b0, rsp_ready = 1'b1;
  logic             req_ready, rsp_valid, busy;
  logic [1:0]       req_op = '0, req_rights = '0;
  logic [1:0]       req_port = '0, req_page = '0;
  logic [2:0]       req_max = '0;
  logic [5:0]       req_width = '0;
  logic [1:0]       rsp_code;
  logic [2:0]       rsp_depth, rsp_elem;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bpt_translator dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_req(input int op, input int port, input int page, input int rights,
                        input int mx, input int width, input int hold,
                        output int code, output int depth, output int elem);
    @(negedge clk);
    req_op = 2'(op); req_port = 2'(port); req_page = 2'(page);
    req_rights = 2'(rights); req_max = 3'(mx); req_width = 6'(width);
    req_valid = 1'b1; rsp_ready = (hold == 0);
    @(negedge clk);
    req_valid = 1'b0;
    for (int w = 0; w < 10 && !rsp_valid; w++) @(negedge clk);
    code = rsp_code; depth = rsp_depth; elem = rsp_elem;
    for (int h = 0; h < hold; h++) begin
      chk(req_ready == 1'b0 && busy == 1'b1, "R9 ready held low", req_ready, 0);
      @(negedge clk);
      chk(rsp_valid == 1'b1 && rsp_code == 2'(code) && rsp_depth == 3'(depth),
          "R9 response held", rsp_code, code);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
  endtask

  task automatic access(input int port, input bit we, input int addr,
                        output bit en, output int elem, output int off, output bit ill);
    @(negedge clk);
    acc_valid[port] = 1'b1; acc_we[port] = we; acc_addr[port] = 6'(addr);
    #1;
    en = bram_en[port]; elem = bram_elem[port]; off = bram_off[port];
    @(negedge clk);
    acc_valid[port] = 1'b0;
    ill = illegal[port];
  endtask

  task automatic t_reset();
    bit en, ill; int e, o;
    chk(req_ready && !rsp_valid && !busy && illegal == '0, "R1 idle after reset", req_ready, 1);
    access(0, 1'b0, 0, en, e, o, ill);
    chk(!en && ill, "R1 unbound port rejected", en, 0);
  endtask

  task automatic t_bad_page();
    int c, d, e;
    do_req(2, 0, 3, 0, 0, 0, 0, c, d, e);
    chk(c == 3, "R8 grow bad page", c, 3);
    do_req(0, 0, 3, 3, 0, 0, 0, c, d, e);
    chk(c == 3, "R8 bind bad page", c, 3);
  endtask

  task automatic t_empty();
    int c, d, e;
    do_req(3, 0, 0, 0, 0, 0, 0, c, d, e);
    chk(c == 2 && d == 0, "R7 shrink empty page", c, 2);
  endtask

  task automatic t_grow_translate();
    int c, d, e, o; bit en, ill;
    do_req(2, 0, 0, 0, 0, 0, 0, c, d, e);
    chk(c == 0 && d == 1 && e == 0, "R5 first grow gets element 0", e, 0);
    do_req(2, 0, 0, 0, 0, 0, 0, c, d, e);
    chk(c == 0 && d == 2 && e == 1, "R5 second grow gets element 1", e, 1);
    do_req(0, 0, 0, 3, 0, 0, 0, c, d, e);
    chk(c == 0 && d == 2, "R12 bind reports depth", d, 2);
    access(0, 1'b0, 'h13, en, e, o, ill);
    chk(en && e == 1 && o == 3 && !ill, "R2 read element 1 offset 3", e, 1);
    access(0, 1'b1, 'h0A, en, e, o, ill);
    chk(en && e == 0 && o == 10, "R2 write element 0 offset 10", o, 10);
    access(0, 1'b0, 'h25, en, e, o, ill);
    chk(!en && ill, "R3 beyond depth rejected", en, 0);
  endtask

  task automatic t_rights();
    int c, d, e, o; bit en, ill;
    do_req(1, 0, 1, 1, 2, 16, 0, c, d, e);
    chk(c == 0 && d == 0, "R11 set page", c, 0);
    do_req(0, 1, 1, 3, 0, 0, 0, c, d, e);
    do_req(2, 0, 1, 0, 0, 0, 0, c, d, e);
    chk(c == 0 && e == 2, "R5 page1 gets element 2", e, 2);
    access(1, 1'b1, 5, en, e, o, ill);
    chk(!en && ill, "R4 write to read-only page", en, 0);
    access(1, 1'b0, 5, en, e, o, ill);
    chk(en && e == 2 && o == 5 && !ill, "R4 read allowed", e, 2);
    chk(bram_width[1] == 6'd16, "R11 width shown", bram_width[1], 16);
    do_req(0, 2, 0, 2, 0, 0, 0, c, d, e);
    access(2, 1'b0, 0, en, e, o, ill);
    chk(!en && ill, "R4 read on write-only port", en, 0);
    access(2, 1'b1, 0, en, e, o, ill);
    chk(en && e == 0, "R4 write on write-only port", e, 0);
  endtask

  task automatic t_full_and_shrink();
    int c, d, e, o; bit en, ill;
    do_req(2, 0, 1, 0, 0, 0, 0, c, d, e);
    chk(c == 0 && e == 3 && d == 2, "R5 page1 second element", e, 3);
    do_req(2, 0, 1, 0, 0, 0, 0, c, d, e);
    chk(c == 1 && d == 2, "R6 grow past max", c, 1);
    access(1, 1'b0, 'h1F, en, e, o, ill);
    chk(en && e == 3, "R6 table unchanged after nack", e, 3);
    do_req(3, 0, 0, 0, 0, 0, 0, c, d, e);
    chk(c == 0 && d == 1 && e == 1, "R7 shrink releases last", e, 1);
    access(0, 1'b0, 'h13, en, e, o, ill);
    chk(!en && ill, "R7 removed element unreachable", en, 0);
    do_req(2, 0, 2, 0, 0, 0, 0, c, d, e);
    chk(c == 0 && e == 1, "R5 reuses lowest free", e, 1);
  endtask

  task automatic t_pool();
    int c, d, e;
    for (int k = 0; k < 3; k++) begin
      do_req(2, 0, 0, 0, 0, 0, 0, c, d, e);
      chk(c == 0 && e == 4 + k, "R5 fill page0", e, 4 + k);
    end
    do_req(2, 0, 0, 0, 0, 0, 0, c, d, e);
    chk(c == 1 && d == 4, "R6 page at max", c, 1);
    do_req(2, 0, 2, 0, 0, 0, 0, c, d, e);
    chk(c == 0 && e == 7, "R5 last free element", e, 7);
    do_req(2, 0, 2, 0, 0, 0, 0, c, d, e);
    chk(c == 1 && d == 2, "R6 pool empty", c, 1);
    do_req(1, 0, 0, 3, 2, 32, 0, c, d, e);
    chk(c == 1 && d == 4, "R11 max below depth", c, 1);
  endtask

  task automatic t_backpressure();
    int c, d, e;
    do_req(0, 3, 2, 1, 0, 0, 3, c, d, e);
    chk(c == 0 && d == 2 && req_ready, "R9 response after hold", c, 0);
  endtask

  task automatic t_same_cycle();
    int e, o, c, d; bit en, ill;
    @(negedge clk);
    req_op = 2'd3; req_page = 2'd0; req_valid = 1'b1; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    acc_valid[0] = 1'b1; acc_we[0] = 1'b0; acc_addr[0] = 6'h32;
    #1;
    chk(bram_en[0] && bram_elem[0] == 3'd6 && bram_off[0] == 4'd2,
        "R10 access during update uses old table", bram_elem[0], 6);
    @(negedge clk);
    acc_valid[0] = 1'b0;
    chk(!illegal[0], "R10 no flag during update", illegal[0], 0);
    chk(rsp_valid && rsp_code == 2'd0 && rsp_elem == 3'd6 && rsp_depth == 3'd3,
        "R7 shrink response", rsp_elem, 6);
    @(negedge clk);
    access(0, 1'b0, 'h32, en, e, o, ill);
    chk(!en && ill, "R10 access after update rejected", en, 0);
    c = 0; d = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_page();
    t_empty();
    t_grow_translate();
    t_rights();
    t_full_and_shrink();
    t_pool();
    t_backpressure();
    t_same_cycle();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule